// File: doc/BRIEF.md
# Configuration Loader Control and Status Registers

This block is the register front end of a peripheral that loads a configuration image into an attached programmable device. Software sets a control word through a simple 32-bit register bus. The fields of that word drive the loader's enable, the target's active-low chip enable, the configuration-reset pull, the clock-to-data ratio, the data-path enable and the data-bus width. The fields leave the block as individual output pins.

A read-only status word merges two pin inputs: the target's 3-bit phase code and its 5-bit mode-select pins. Software reads it to follow the target through power-up, reset, configuration, initialisation and user mode.

A configuration-clock counter sends a software-chosen number of clock pulses to the target. When the last pulse ends, it raises a done flag. Software clears that flag by writing 1 to it. Reads are combinational on the bus address. Writes take effect at the clock edge where the write enable is sampled high.

Top module: `cfgctl_regs`

## Requirements
- R1: The four registers sit at byte offsets 0x0 (status), 0x4 (control), 0x8 (clock count) and 0xC (clock done). A read of any other offset returns 0.
- R2: A status read returns the phase input in bits [2:0] and the mode-select input in bits [7:3], with all higher bits 0. The phase codes are 0 power-up, 1 reset, 2 configuration, 3 initialisation, 4 user mode and 5 unknown.
- R3: A write to the status offset has no effect on any register or output.
- R4: The control register holds the following fields, and each drives its own output pin:
  - bit 0: enable
  - bit 1: active-low chip enable
  - bit 2: configuration-reset pull, where 1 holds the target in reset
  - bits [7:6]: ratio, where 0=x1, 1=x2, 2=x4, 3=x8
  - bit 8: data-path enable
  - bit 9: width, where 0 is 16-bit and 1 is 32-bit
  A control read returns these fields and 0 in every other bit.
- R5: Writing a count N greater than 0 (bits [CNT_W-1:0] of the write data) produces exactly N clock pulses. Each pulse is high for one system clock and low for one. The first high cycle is the second cycle after the write edge.
- R6: Bit 0 of the done register becomes 1 at the edge that ends the last pulse, which is 2N edges after the write edge. All other bits of the done register read 0.
- R7: Writing a count of 0 produces no pulse and sets the done flag at the next edge.
- R8: Writing 1 to bit 0 of the done register clears the flag, and writing 0 leaves it unchanged. If the flag is set and cleared in the same cycle, the set wins.
- R9: Writing a new count during a countdown restarts it: exactly the new number of pulses follows the second write.
- R10: Reset clears the control register and all control pins, stops the counter, clears the done flag and holds the clock output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| phase_in | input | 3 | Target phase code |
| msel_in | input | 5 | Target mode-select pins |
| ctl_enable | output | 1 | Loader enable |
| ctl_nce | output | 1 | Active-low chip enable |
| ctl_cfg_pull | output | 1 | Configuration-reset pull |
| ctl_ratio | output | 2 | Clock-to-data ratio code |
| ctl_data_en | output | 1 | Configuration data-path enable |
| ctl_width32 | output | 1 | Data width select (1 = 32-bit) |
| dclk_out | output | 1 | Configuration clock pulses |

## Verification
The bench builds the block with its default parameters: an 8-bit address and a 16-bit count. The wide address reaches offsets above the map, such as 0x10 and 0x80, and misaligned offsets. Counts of 0, 1, 4 and 7, a restart and a set-versus-clear collision can each be traced edge by edge within a few dozen cycles. The pulse count and the cycle of the done flag are measured against 2N+1 sampling points after the write.

// File: rtl/cfgctl_pkg.sv
package cfgctl_pkg;
  localparam int BUS_W = 32;

  localparam logic [7:0] OFS_STATUS = 8'h00;
  localparam logic [7:0] OFS_CTRL   = 8'h04;
  localparam logic [7:0] OFS_DCNT   = 8'h08;
  localparam logic [7:0] OFS_DSTAT  = 8'h0C;

  typedef enum logic [2:0] {
    PH_POWERUP = 3'd0,
    PH_RESET   = 3'd1,
    PH_CONFIG  = 3'd2,
    PH_INIT    = 3'd3,
    PH_USER    = 3'd4,
    PH_UNKNOWN = 3'd5
  } phase_e;

  typedef struct packed {
    logic       width32;
    logic       data_en;
    logic [1:0] ratio;
    logic       cfg_pull;
    logic       nce;
    logic       enable;
  } ctrl_t;

  function automatic ctrl_t ctrl_unpack(input logic [9:0] w);
    ctrl_t c;
    c.enable   = w[0];
    c.nce      = w[1];
    c.cfg_pull = w[2];
    c.ratio    = w[7:6];
    c.data_en  = w[8];
    c.width32  = w[9];
    return c;
  endfunction

  function automatic logic [BUS_W-1:0] ctrl_pack(input ctrl_t c);
    return {22'b0, c.width32, c.data_en, c.ratio, 3'b000, c.cfg_pull, c.nce, c.enable};
  endfunction

  function automatic logic [BUS_W-1:0] status_pack(input logic [2:0] ph, input logic [4:0] ms);
    return {24'b0, ms, ph};
  endfunction
endpackage

// File: rtl/cfgctl_ctrl_reg.sv
module cfgctl_ctrl_reg
  import cfgctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [9:0] wr_bits,
  output ctrl_t      ctrl_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= ctrl_unpack(wr_bits);
  end
endmodule

// File: rtl/cfgctl_dclk_gen.sv
module cfgctl_dclk_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clr_req,
  output logic             dclk,
  output logic             done,
  output logic             busy,
  output logic             done_set
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] remain;
  logic             last_fall;

  assign last_fall = busy && dclk && (remain == ONE);
  assign done_set  = load ? (load_val == '0) : last_fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
      busy   <= 1'b0;
      dclk   <= 1'b0;
    end else if (load) begin
      remain <= load_val;
      busy   <= (load_val != '0);
      dclk   <= 1'b0;
    end else if (busy) begin
      if (dclk) begin
        dclk   <= 1'b0;
        remain <= remain - ONE;
        if (remain == ONE) busy <= 1'b0;
      end else begin
        dclk <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        done <= 1'b0;
    else if (done_set) done <= 1'b1;
    else if (clr_req)  done <= 1'b0;
  end
endmodule

// File: rtl/cfgctl_regs.sv
module cfgctl_regs
  import cfgctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [2:0]        phase_in,
  input  logic [4:0]        msel_in,
  output logic              ctl_enable,
  output logic              ctl_nce,
  output logic              ctl_cfg_pull,
  output logic [1:0]        ctl_ratio,
  output logic              ctl_data_en,
  output logic              ctl_width32,
  output logic              dclk_out
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_DCNT   = ADDR_W'(OFS_DCNT);
  localparam logic [ADDR_W-1:0] A_DSTAT  = ADDR_W'(OFS_DSTAT);

  logic  hit_ctrl, hit_dcnt, hit_dstat;
  ctrl_t ctrl_q;
  logic  dclk_done, dclk_busy, done_set;

  assign hit_ctrl  = bus_addr == A_CTRL;
  assign hit_dcnt  = bus_addr == A_DCNT;
  assign hit_dstat = bus_addr == A_DSTAT;

  cfgctl_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_we && hit_ctrl),
    .wr_bits (bus_wdata[9:0]),
    .ctrl_q  (ctrl_q)
  );

  cfgctl_dclk_gen #(.CNT_W(CNT_W)) u_dclk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (bus_we && hit_dcnt),
    .load_val (bus_wdata[CNT_W-1:0]),
    .clr_req  (bus_we && hit_dstat && bus_wdata[0]),
    .dclk     (dclk_out),
    .done     (dclk_done),
    .busy     (dclk_busy),
    .done_set (done_set)
  );

  assign ctl_enable   = ctrl_q.enable;
  assign ctl_nce      = ctrl_q.nce;
  assign ctl_cfg_pull = ctrl_q.cfg_pull;
  assign ctl_ratio    = ctrl_q.ratio;
  assign ctl_data_en  = ctrl_q.data_en;
  assign ctl_width32  = ctrl_q.width32;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_STATUS) bus_rdata = status_pack(phase_in, msel_in);
    else if (hit_ctrl)        bus_rdata = ctrl_pack(ctrl_q);
    else if (hit_dstat)       bus_rdata = {31'b0, dclk_done};
  end
endmodule

// File: rtl/cfgctl_regs_chk.sv
module cfgctl_regs_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [2:0]        phase_in,
  input logic [4:0]        msel_in,
  input logic              ctl_enable,
  input logic              dclk_out,
  input logic              dclk_done,
  input logic              dclk_busy,
  input logic              done_set
);
  logic w_cnt, w_stat, mapped;
  assign w_cnt  = bus_we && (bus_addr == ADDR_W'(8'h08));
  assign w_stat = bus_we && (bus_addr == ADDR_W'(8'h0C));
  assign mapped = (bus_addr == ADDR_W'(8'h00)) || (bus_addr == ADDR_W'(8'h04)) ||
                  (bus_addr == ADDR_W'(8'h08)) || (bus_addr == ADDR_W'(8'h0C));

  a_r1_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> bus_rdata == 32'h0);
  a_r2_status_word: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == ADDR_W'(8'h00) |-> bus_rdata == {24'h0, msel_in, phase_in});
  a_r4_enable_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(8'h04)) |=> ctl_enable == $past(bus_wdata[0]));
  a_r5_high_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    dclk_out |=> !dclk_out);
  a_r5_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !dclk_busy |-> !dclk_out);
  a_r6_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dclk_done) |-> ($past(dclk_out) || $past(w_cnt)));
  a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (w_stat && bus_wdata[0] && !done_set) |=> !dclk_done);
  a_r8_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (w_stat && !bus_wdata[0] && !w_cnt && dclk_done) |=> dclk_done);
endmodule

bind cfgctl_regs cfgctl_regs_chk #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_cfgctl_regs.sv
`timescale 1ns/1ps
module test_cfgctl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  phase_in = '0;
  logic [4:0]  msel_in = '0;
  logic        ctl_enable, ctl_nce, ctl_cfg_pull, ctl_data_en, ctl_width32, dclk_out;
  logic [1:0]  ctl_ratio;
  int n_checks = 0, n_fail = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  cfgctl_regs i_cfgctl_regs (.*);

  localparam int NV = 10;
  localparam logic [31:0] CTRL_VEC [NV] = '{32'h1, 32'h2, 32'h4, 32'h40, 32'h80,
                                           32'hC0, 32'h100, 32'h200, 32'hFFFFFFFF, 32'h0};

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic measure(input int lim, output int pulses, output int done_at);
    pulses = 0; done_at = -1;
    for (int k = 1; k <= lim; k++) begin
      if (k > 1) @(negedge clk);
      bus_addr = 8'h0C; #1;
      if (dclk_out) pulses++;
      if (done_at < 0 && bus_rdata[0]) done_at = k;
    end
  endtask

  function automatic logic [31:0] exp_ctrl(input logic [31:0] v);
    return v & 32'h0000_03C7;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    int p, d;
    repeat (3) @(negedge clk);
    // R10 reset state
    check({ctl_enable, ctl_nce, ctl_cfg_pull, ctl_ratio, ctl_data_en, ctl_width32, dclk_out} == 8'h0,
          "R10 pins in reset", {24'h0, ctl_enable, ctl_nce, ctl_cfg_pull, ctl_ratio, ctl_data_en, ctl_width32, dclk_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    bus_read(8'h04, rd); check(rd == 0, "R10 control after reset", rd, 0);
    bus_read(8'h0C, rd); check(rd == 0, "R10 done after reset", rd, 0);

    // R4 control vectors
    for (int i = 0; i < NV; i++) begin
      bus_write(8'h04, CTRL_VEC[i]);
      bus_read(8'h04, rd);
      check(rd == exp_ctrl(CTRL_VEC[i]), "R4 control readback", rd, exp_ctrl(CTRL_VEC[i]));
      check({ctl_width32, ctl_data_en, ctl_ratio, ctl_cfg_pull, ctl_nce, ctl_enable} ==
            {CTRL_VEC[i][9:6], CTRL_VEC[i][2:0]}, "R4 control pins",
            {25'h0, ctl_width32, ctl_data_en, ctl_ratio, ctl_cfg_pull, ctl_nce, ctl_enable},
            {25'h0, CTRL_VEC[i][9:6], CTRL_VEC[i][2:0]});
    end

    // R2 status word over all phase codes
    for (int ph = 0; ph < 6; ph++) begin
      phase_in = 3'(ph); msel_in = 5'(ph * 5 + 3);
      bus_read(8'h00, rd);
      check(rd == {24'h0, msel_in, phase_in}, "R2 status word", rd, {24'h0, msel_in, phase_in});
    end

    // R3 status write ignored
    bus_write(8'h04, 32'h0000_0245);
    bus_write(8'h00, 32'hFFFF_FFFF);
    bus_read(8'h00, rd);
    check(rd == {24'h0, msel_in, phase_in}, "R3 status unchanged", rd, {24'h0, msel_in, phase_in});
    bus_read(8'h04, rd); check(rd == 32'h245, "R3 control unchanged", rd, 32'h245);
    bus_read(8'h0C, rd); check(rd == 0, "R3 done unchanged", rd, 0);
    check(!dclk_out, "R3 no pulse", {31'h0, dclk_out}, 0);

    // R1 unmapped offsets
    bus_read(8'h10, rd); check(rd == 0, "R1 offset 0x10", rd, 0);
    bus_read(8'h05, rd); check(rd == 0, "R1 offset 0x05", rd, 0);
    bus_read(8'h80, rd); check(rd == 0, "R1 offset 0x80", rd, 0);
    bus_read(8'h08, rd); check(rd == 0, "R1 count offset reads 0", rd, 0);

    // R5 / R6 pulse counts
    foreach (CTRL_VEC[j]) begin end
    for (int t = 0; t < 3; t++) begin
      int n;
      n = (t == 0) ? 1 : (t == 1) ? 4 : 7;
      bus_write(8'h08, n);
      measure(2 * n + 4, p, d);
      check(p == n, "R5 pulse count", p, n);
      check(d == 2 * n + 1, "R6 done timing", d, 2 * n + 1);
      bus_write(8'h0C, 32'h1);
    end

    // R7 count zero
    bus_write(8'h08, 0);
    measure(4, p, d);
    check(p == 0, "R7 no pulse", p, 0);
    check(d == 1, "R7 done next edge", d, 1);

    // R8 write 0 keeps, write 1 clears
    bus_write(8'h0C, 32'h0);
    bus_read(8'h0C, rd); check(rd == 1, "R8 zero write keeps", rd, 1);
    bus_write(8'h0C, 32'hFFFF_FFFE);
    bus_read(8'h0C, rd); check(rd == 1, "R8 bit0 clear keeps", rd, 1);
    bus_write(8'h0C, 32'h1);
    bus_read(8'h0C, rd); check(rd == 0, "R8 w1c clears", rd, 0);

    // R8 set wins over clear in the same cycle
    bus_write(8'h08, 1);
    @(negedge clk);
    bus_write(8'h0C, 32'h1);
    bus_read(8'h0C, rd); check(rd == 1, "R8 set beats clear", rd, 1);
    bus_write(8'h0C, 32'h1);

    // R9 restart
    bus_write(8'h08, 5);
    measure(3, p, d);
    check(p == 1 && d < 0, "R9 before restart", p, 1);
    @(negedge clk);
    bus_write(8'h08, 2);
    measure(10, p, d);
    check(p == 2, "R9 pulses after restart", p, 2);
    check(d == 5, "R9 done after restart", d, 5);
    bus_write(8'h0C, 32'h1);

    // R10 reset mid-run
    bus_write(8'h04, 32'h3FF);
    bus_write(8'h08, 10);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    measure(6, p, d);
    check(p == 0 && d < 0, "R10 counter stopped", p, 0);
    bus_read(8'h04, rd); check(rd == 0, "R10 control cleared", rd, 0);

    finish_run();
  end
endmodule